// File: doc/BRIEF.md
# Ethernet Interrupt Status Controller

This block gathers the event pulses from a gigabit Ethernet engine into a status register. The transmit and receive datapaths produce those pulses. The block turns the latched bits into three interrupt lines. The status bits are:

- six error conditions, raised while the engine works on a transmit descriptor or while the engine is being accessed;
- one receive-packet indication;
- one auxiliary indication.

Software reads the status and mask registers through a plain single-cycle register port. It clears a status bit by writing 1 to that bit.

The receive-packet line re-arms itself differently from the others. When it fires, the hardware sets mask bit 0, so the line is high for exactly one cycle. Software re-arms it by writing that mask bit back to 0. The error line and the auxiliary line are level outputs, and only software changes their mask bits.

Top module: `gige_irq_ctrl`

## Requirements
- R1: After reset, status reads 0, mask bits 7:0 read 0, mask bits 63:8 read 1, and all three interrupt lines are low.
- R2: A one-cycle event pulse sets its status bit at the next clock edge, and the bit stays set until software clears it. Bit positions: 0 receive packet; 1 hardware access error; 2 transmit checksum inputs invalid; 3 transmit frame below 60 bytes; 4 transmit index beyond work-queue size; 5 software configuration error; 6 software access error; 7 auxiliary.
- R3: The status register sits at offset 0x0. A write of 1 to a status bit clears it, and a write of 0 leaves it unchanged.
- R4: If an event and a clear of the same bit arrive in the same cycle, the bit is set afterwards.
- R5: `irq_err` is high, as a level, whenever any of status bits 6:1 is set while the mask bit at the same position is 0.
- R6: `irq_rx` is status bit 0 AND NOT mask bit 0. On the clock edge after `irq_rx` is high, the hardware sets mask bit 0, so `irq_rx` lasts one cycle.
- R7: If status bit 0 is still set when software writes mask bit 0 to 0, `irq_rx` rises again after that write.
- R8: `irq_aux` is status bit 7 AND NOT mask bit 7.
- R9: The mask register sits at offset 0x8, and bits 7:0 take the written value. Bits 63:8 always read 1 and ignore writes. A hardware set of mask bit 0 wins over a software write of 0 in the same cycle.
- R10: Clearing the error bits with bit 0 written as 0 leaves the receive status bit set. Reads from any offset other than 0x0 and 0x8 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational from `reg_addr` |
| err_evt | input | 6 | Error event pulses; err_evt[k] drives status bit k+1 |
| rx_evt | input | 1 | Receive-packet event pulse |
| aux_evt | input | 1 | Auxiliary event pulse |
| irq_err | output | 1 | Combined error interrupt (level) |
| irq_rx | output | 1 | Receive-packet interrupt (self-masking) |
| irq_aux | output | 1 | Auxiliary interrupt (level) |

## Verification
Three rules are checked on every cycle, per bit:

- the status bits obey set, write-1-to-clear and hold;
- the hardware sets mask bit 0 after the receive line fires;
- the receive line never stays high for two cycles in a row.

Only the directed scenarios show the rest:

- the reset values, including the mask bits 63:8 that are fixed at 1;
- the level behaviour of the error and auxiliary lines under masking;
- re-arming the receive line while its status bit is still pending;
- the two same-cycle conflicts, a set against a clear and a hardware mask set against a software write.

// File: rtl/gige_irq_pkg.sv
package gige_irq_pkg;
   localparam int RX_BIT  = 0;
   localparam int ERR_LSB = 1;

   typedef struct packed {
      logic stat_wr;
      logic mask_wr;
   } reg_dec_t;
endpackage

// File: rtl/gige_irq_status.sv
module gige_irq_status #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic [NUM_SRC-1:0] clr,
   output logic [NUM_SRC-1:0] st_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) st_q[i] <= 1'b0;
         else        st_q[i] <= evt[i] | (st_q[i] & ~clr[i]);
      end

      AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> st_q[i]);                               // R4
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !evt[i]) |=> !st_q[i]);                 // R3
      AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr[i] && !evt[i]) |=> $stable(st_q[i]));        // R2
   end
endmodule

// File: rtl/gige_irq_mask.sv
module gige_irq_mask #(
   parameter int NUM_SRC      = 8,
   parameter bit RX_AUTO_MASK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [NUM_SRC-1:0] wdata,
   input  logic               rx_fire,
   output logic [NUM_SRC-1:0] mk_q
);
   import gige_irq_pkg::*;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      if (i == RX_BIT && RX_AUTO_MASK) begin : g_auto
         always_ff @(posedge clk) begin
            if (!rst_n)       mk_q[i] <= 1'b0;
            else if (rx_fire) mk_q[i] <= 1'b1;
            else if (wr)      mk_q[i] <= wdata[i];
         end
         AST_AUTOMASK: assert property (@(posedge clk) disable iff (!rst_n)
            rx_fire |=> mk_q[i]);                           // R6
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)  mk_q[i] <= 1'b0;
            else if (wr) mk_q[i] <= wdata[i];
         end
      end
   end

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !rx_fire) |=> $stable(mk_q));                 // R9
endmodule

// File: rtl/gige_irq_gen.sv
module gige_irq_gen #(
   parameter int NUM_ERR = 6
) (
   input  logic [NUM_ERR+1:0] st,
   input  logic [NUM_ERR+1:0] mk,
   output logic               irq_err,
   output logic               irq_rx,
   output logic               irq_aux
);
   import gige_irq_pkg::*;
   localparam int AUX_BIT = NUM_ERR + 1;

   logic [NUM_ERR-1:0] err_live;

   always_comb begin
      err_live = st[ERR_LSB +: NUM_ERR] & ~mk[ERR_LSB +: NUM_ERR];
      irq_err  = |err_live;
      irq_rx   = st[RX_BIT] & ~mk[RX_BIT];
      irq_aux  = st[AUX_BIT] & ~mk[AUX_BIT];
   end
endmodule

// File: rtl/gige_irq_ctrl.sv
module gige_irq_ctrl #(
   parameter int DATA_W       = 64,
   parameter int ADDR_W       = 4,
   parameter int NUM_ERR      = 6,
   parameter int STAT_OFS     = 0,
   parameter int MASK_OFS     = 8,
   parameter bit RX_AUTO_MASK = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_ERR-1:0]  err_evt,
   input  logic                rx_evt,
   input  logic                aux_evt,
   output logic                irq_err,
   output logic                irq_rx,
   output logic                irq_aux
);
   import gige_irq_pkg::*;

   localparam int NUM_SRC = NUM_ERR + 2;
   localparam int PAD_W   = DATA_W - NUM_SRC;

   if (NUM_SRC > DATA_W) begin : g_chk_width
      $error("source count exceeds register width");
   end
   if (STAT_OFS == MASK_OFS) begin : g_chk_ofs
      $error("status and mask offsets collide");
   end
   if (STAT_OFS >= (1 << ADDR_W) || MASK_OFS >= (1 << ADDR_W)) begin : g_chk_addr
      $error("register offset out of address range");
   end

   reg_dec_t           dec;
   logic [NUM_SRC-1:0] evt_vec, clr_vec, st_q, mk_q;

   always_comb begin
      dec.stat_wr = reg_wr && (reg_addr == ADDR_W'(STAT_OFS));
      dec.mask_wr = reg_wr && (reg_addr == ADDR_W'(MASK_OFS));
      evt_vec     = {aux_evt, err_evt, rx_evt};
      clr_vec     = dec.stat_wr ? reg_wdata[NUM_SRC-1:0] : '0;
   end

   gige_irq_status #(.NUM_SRC(NUM_SRC)) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt_vec),
      .clr   (clr_vec),
      .st_q  (st_q)
   );

   gige_irq_mask #(.NUM_SRC(NUM_SRC), .RX_AUTO_MASK(RX_AUTO_MASK)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (dec.mask_wr),
      .wdata   (reg_wdata[NUM_SRC-1:0]),
      .rx_fire (irq_rx),
      .mk_q    (mk_q)
   );

   gige_irq_gen #(.NUM_ERR(NUM_ERR)) u_gen (
      .st      (st_q),
      .mk      (mk_q),
      .irq_err (irq_err),
      .irq_rx  (irq_rx),
      .irq_aux (irq_aux)
   );

   always_comb begin
      if (reg_addr == ADDR_W'(STAT_OFS))      reg_rdata = {{PAD_W{1'b0}}, st_q};
      else if (reg_addr == ADDR_W'(MASK_OFS)) reg_rdata = {{PAD_W{1'b1}}, mk_q};
      else                                    reg_rdata = '0;
   end

   if (RX_AUTO_MASK) begin : g_oneshot
      AST_RX_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
         irq_rx |=> !irq_rx);                               // R6
   end
endmodule

// File: tb/gige_irq_ctrl_bench.sv
module gige_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [5:0]  err_evt = '0;
   logic        rx_evt = 1'b0, aux_evt = 1'b0;
   logic        irq_err, irq_rx, irq_aux;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   localparam logic [63:0] MASK_RST = 64'hFFFF_FFFF_FFFF_FF00;

   always #4 clk = ~clk;

   gige_irq_ctrl u_gige_irq_ctrl (
      .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
      .err_evt, .rx_evt, .aux_evt, .irq_err, .irq_rx, .irq_aux
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(logic [3:0] a, output logic [63:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wr(logic [3:0] a, logic [63:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      #1;
   endtask

   task automatic pulse(logic [5:0] e, logic r, logic x);
      @(negedge clk);
      err_evt = e; rx_evt = r; aux_evt = x;
      @(negedge clk);
      err_evt = '0; rx_evt = 1'b0; aux_evt = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      logic [63:0] d;
      rd(4'h0, d); check("R1 status", d, 64'h0);
      rd(4'h8, d); check("R1 mask", d, MASK_RST);
      check("R1 irqs", {irq_err, irq_rx, irq_aux}, 3'b000);
   endtask

   task automatic t_err_latch();
      logic [63:0] d;
      pulse(6'b000010, 1'b0, 1'b0);             // checksum -> bit 2
      rd(4'h0, d); check("R2 latch bit2", d, 64'h4);
      check("R5 irq_err level", irq_err, 1'b1);
      repeat (3) @(negedge clk);
      #1 check("R2 hold", irq_err, 1'b1);
      wr(4'h0, 64'h0);
      rd(4'h0, d); check("R3 write0 keeps", d, 64'h4);
      wr(4'h0, 64'h4);
      rd(4'h0, d); check("R3 write1 clears", d, 64'h0);
      check("R5 irq_err low", irq_err, 1'b0);
   endtask

   task automatic t_err_mask();
      logic [63:0] d;
      wr(4'h8, 64'h10);
      pulse(6'b001000, 1'b0, 1'b0);             // index -> bit 4
      rd(4'h0, d); check("R2 latch bit4", d, 64'h10);
      check("R5 masked", irq_err, 1'b0);
      wr(4'h8, 64'h0);
      check("R5 unmasked", irq_err, 1'b1);
      wr(4'h0, 64'h10);
   endtask

   task automatic t_rx();
      logic [63:0] d;
      pulse(6'b000001, 1'b1, 1'b0);             // rx + hw access
      check("R6 irq_rx fires", irq_rx, 1'b1);
      @(negedge clk); #1;
      check("R6 irq_rx one cycle", irq_rx, 1'b0);
      rd(4'h8, d); check("R6 automask", d, MASK_RST | 64'h1);
      wr(4'h0, 64'hFE);
      rd(4'h0, d); check("R10 rx kept", d, 64'h1);
      check("R10 errs gone", irq_err, 1'b0);
      wr(4'h8, 64'h0);
      check("R7 rearm", irq_rx, 1'b1);
      @(negedge clk); #1;
      check("R7 remasked", irq_rx, 1'b0);
      wr(4'h0, 64'h1);
      wr(4'h8, 64'h0);
      check("R7 no refire", irq_rx, 1'b0);
   endtask

   task automatic t_collide();
      logic [63:0] d;
      @(negedge clk);
      err_evt = 6'b100000;
      reg_addr = 4'h0; reg_wdata = 64'h40; reg_wr = 1'b1;
      @(negedge clk);
      err_evt = '0; reg_wr = 1'b0;
      rd(4'h0, d); check("R4 event wins", d, 64'h40);
      wr(4'h0, 64'h40);
   endtask

   task automatic t_mask_collide();
      logic [63:0] d;
      pulse(6'b0, 1'b1, 1'b0);
      check("R6 fire", irq_rx, 1'b1);
      reg_addr = 4'h8; reg_wdata = 64'h0; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      rd(4'h8, d); check("R9 hw set wins", d, MASK_RST | 64'h1);
      wr(4'h0, 64'h1);
      wr(4'h8, 64'h0);
   endtask

   task automatic t_aux();
      logic [63:0] d;
      pulse(6'b0, 1'b0, 1'b1);
      check("R8 irq_aux", irq_aux, 1'b1);
      rd(4'h0, d); check("R2 latch bit7", d, 64'h80);
      wr(4'h8, 64'h80);
      check("R8 masked", irq_aux, 1'b0);
      rd(4'h8, d); check("R9 readback", d, MASK_RST | 64'h80);
      rd(4'h4, d); check("R10 other offset", d, 64'h0);
      wr(4'h0, 64'h80);
      rd(4'h0, d); check("R3 aux clear", d, 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_err_latch();
      t_err_mask();
      t_rx();
      t_collide();
      t_mask_collide();
      t_aux();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule